// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Unit

This block is the purely combinational hazard controller for an in-order pipeline with fetch, decode, execute, memory and writeback stages. It looks at the source register indices of the instructions in decode and execute and at the destinations of the instructions further down the pipe. From these it chooses a bypass source for each execute-stage ALU operand, holds the front of the pipe while a loaded value is not yet available, and discards wrong-path work when a branch is taken.

Pipeline registers, the ALU, the register file and the branch comparator all sit outside the block. The surrounding pipeline feeds `stall_fetch_o` to the PC enable and `stall_dec_o` to the fetch/decode register enable, both active high as hold requests. It uses `flush_dec_o` and `flush_exe_o` as synchronous clears of the decode and execute pipeline registers. Branches are assumed not taken. `br_taken_i` is raised while a branch in execute resolves taken, and at that point the instructions in fetch and decode are on the wrong path.

Top module: `hazard_ctrl`

## Requirements
- R1: An operand select is 2'b10 (memory-stage ALU result) when the memory stage writes a register (`mem_wen_i`), its destination is not register 0, and it equals that operand's execute-stage source index.
- R2: When R1 does not apply, the select is 2'b01 (writeback result) if the writeback stage writes a non-zero destination equal to the operand's source index. This means a memory-stage match wins over a writeback-stage match.
- R3: When neither R1 nor R2 applies, the select is 2'b00 (register file value). The code 2'b11 never appears.
- R4: A destination of register 0, or a stage whose write flag is low, never causes forwarding, even when the indices are equal.
- R5: `fwd_a_o` compares `rs_exe_i` and `fwd_b_o` compares `rt_exe_i` under the same rules. Each select depends only on its own source index.
- R6: Load-use interlock: when `exe_is_load_i` is high, `rt_exe_i` equals `rs_dec_i` or `rt_dec_i`, and no branch is taken, then `stall_fetch_o`, `stall_dec_o` and `flush_exe_o` are 1 and `flush_dec_o` is 0.
- R7: With `exe_is_load_i` low, matching indices between decode and execute cause no stall and no flush.
- R8: When `br_taken_i` is high, `flush_dec_o` and `flush_exe_o` are 1 and both stall outputs are 0, whatever the load-use condition is.
- R9: With no load-use match and no taken branch, all four stall and flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_dec_i | input | AW | First source index of the instruction in decode |
| rt_dec_i | input | AW | Second source index of the instruction in decode |
| rs_exe_i | input | AW | First source index of the instruction in execute |
| rt_exe_i | input | AW | Second source index in execute; also the destination of a load |
| exe_is_load_i | input | 1 | Instruction in execute writes a register from memory |
| mem_dst_i | input | AW | Destination index of the instruction in memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | AW | Destination index of the instruction in writeback |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| fwd_a_o | output | 2 | Bypass select for ALU operand A |
| fwd_b_o | output | 2 | Bypass select for ALU operand B |
| stall_fetch_o | output | 1 | Hold the PC |
| stall_dec_o | output | 1 | Hold the fetch/decode register |
| flush_dec_o | output | 1 | Clear the fetch/decode register |
| flush_exe_o | output | 1 | Clear the decode/execute register (bubble) |

## Verification
The block holds no state, so any fault in its comparators or priority logic shows at the ports in the same cycle the offending index pattern is applied. A reversed priority shows up only when memory and writeback both target the operand's source. A missing zero-register guard shows up only when a destination of 0 meets a source of 0. For this reason the random stimulus draws indices from a small range, so these coincidences happen often. A missing branch override shows up as a stall asserted together with a taken branch, which would freeze the PC on the wrong path instead of redirecting it.

// File: rtl/hazard_pkg.sv
// Shared types for the hazard controller.
package hazard_pkg;
    // Bypass source for one execute-stage ALU operand.
    typedef enum logic [1:0] {
        FWD_REGFILE = 2'b00,
        FWD_WBACK   = 2'b01,
        FWD_MEMALU  = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
// Bypass selection for one ALU operand.
// Picks the youngest in-flight producer of the operand's source register.
// Assumes register 0 is hard-wired to zero and is never a real producer.
module fwd_select
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_dst_i,
    input  logic          mem_wen_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_wen_i,
    output fwd_sel_e      sel_o
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    // Producer match per stage, ignoring the zero register and idle writers.
    always_comb begin
        mem_hit = mem_wen_i && (mem_dst_i != ZERO_REG) && (mem_dst_i == src_i);
        wb_hit  = wb_wen_i  && (wb_dst_i  != ZERO_REG) && (wb_dst_i  == src_i);
    end

    // Priority pick: memory stage holds the younger value.
    always_comb begin
        if (mem_hit)     sel_o = FWD_MEMALU;
        else if (wb_hit) sel_o = FWD_WBACK;
        else             sel_o = FWD_REGFILE;
    end

    // Guards on the chosen source against the raw stage inputs.
    always_comb begin
        p_mem_needs_writer_r1: assert (sel_o != FWD_MEMALU || (mem_wen_i && mem_dst_i == src_i))
            else $error("memory bypass without matching writer");
        p_no_zero_bypass_r4: assert (src_i != ZERO_REG || sel_o == FWD_REGFILE)
            else $error("register 0 was bypassed");
        p_legal_code_r3: assert (sel_o != 2'b11)
            else $error("illegal bypass code");
    end
endmodule

// File: rtl/load_use_detect.sv
// Load-use interlock detection between decode and execute.
// Assumes a load's destination index arrives on the execute rt index.
module load_use_detect #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rs_dec_i,
    input  logic [AW-1:0] rt_dec_i,
    input  logic [AW-1:0] rt_exe_i,
    input  logic          exe_is_load_i,
    output logic          luse_o
);
    // Consumer in decode needs the value the load in execute has not fetched yet.
    always_comb begin
        luse_o = exe_is_load_i && ((rs_dec_i == rt_exe_i) || (rt_dec_i == rt_exe_i));
    end

    // A stall request always comes from a load.
    always_comb begin
        p_luse_needs_load_r7: assert (!luse_o || exe_is_load_i)
            else $error("interlock without a load");
    end
endmodule

// File: rtl/pipe_steer.sv
// Turns the interlock request and the branch outcome into hold and clear controls.
// Assumes branches are predicted not taken and resolve in execute.
module pipe_steer (
    input  logic luse_i,
    input  logic br_taken_i,
    output logic stall_fetch_o,
    output logic stall_dec_o,
    output logic flush_dec_o,
    output logic flush_exe_o
);
    logic hold;

    // A taken branch redirects the PC, so it overrides any hold request.
    always_comb begin
        hold          = luse_i && !br_taken_i;
        stall_fetch_o = hold;
        stall_dec_o   = hold;
        flush_dec_o   = br_taken_i;
        flush_exe_o   = hold || br_taken_i;
    end

    // Consistency of the control bundle.
    always_comb begin
        p_branch_no_hold_r8: assert (!(br_taken_i && (stall_fetch_o || stall_dec_o)))
            else $error("hold during taken branch");
        p_hold_bubbles_r6: assert (!stall_dec_o || (stall_fetch_o && flush_exe_o && !flush_dec_o))
            else $error("hold without bubble");
        p_quiet_r9: assert (luse_i || br_taken_i || !(stall_fetch_o || flush_exe_o || flush_dec_o))
            else $error("spurious control");
    end
endmodule

// File: rtl/hazard_ctrl.sv
// Hazard controller for a five-stage in-order pipeline.
// Combines per-operand bypass selection, a load-use interlock and
// wrong-path flushing under a not-taken branch policy. Purely combinational.
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rs_dec_i,
    input  logic [AW-1:0] rt_dec_i,
    input  logic [AW-1:0] rs_exe_i,
    input  logic [AW-1:0] rt_exe_i,
    input  logic          exe_is_load_i,
    input  logic [AW-1:0] mem_dst_i,
    input  logic          mem_wen_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_wen_i,
    input  logic          br_taken_i,
    output logic [1:0]    fwd_a_o,
    output logic [1:0]    fwd_b_o,
    output logic          stall_fetch_o,
    output logic          stall_dec_o,
    output logic          flush_dec_o,
    output logic          flush_exe_o
);
    localparam int NUM_OPS = 2;

    logic [AW-1:0] op_src [NUM_OPS];
    fwd_sel_e      op_sel [NUM_OPS];
    logic          luse;

    // Execute-stage source index per operand slot.
    always_comb begin
        op_src[0] = rs_exe_i;
        op_src[1] = rt_exe_i;
    end

    // One bypass selector per ALU operand.
    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        fwd_select #(.AW(AW)) u_fwd (
            .src_i     (op_src[gi]),
            .mem_dst_i (mem_dst_i),
            .mem_wen_i (mem_wen_i),
            .wb_dst_i  (wb_dst_i),
            .wb_wen_i  (wb_wen_i),
            .sel_o     (op_sel[gi])
        );
    end

    assign fwd_a_o = op_sel[0];
    assign fwd_b_o = op_sel[1];

    load_use_detect #(.AW(AW)) u_luse (
        .rs_dec_i      (rs_dec_i),
        .rt_dec_i      (rt_dec_i),
        .rt_exe_i      (rt_exe_i),
        .exe_is_load_i (exe_is_load_i),
        .luse_o        (luse)
    );

    pipe_steer u_steer (
        .luse_i        (luse),
        .br_taken_i    (br_taken_i),
        .stall_fetch_o (stall_fetch_o),
        .stall_dec_o   (stall_dec_o),
        .flush_dec_o   (flush_dec_o),
        .flush_exe_o   (flush_exe_o)
    );

    // Both operands see the same writers: equal sources must get equal selects.
    always_comb begin
        p_ops_agree_r5: assert (rs_exe_i != rt_exe_i || fwd_a_o == fwd_b_o)
            else $error("operand selects disagree on equal sources");
    end
endmodule

// File: tb/hazard_ctrl_bench.sv
// Self-checking bench: random index patterns drawn from a small range, plus directed corners.
module hazard_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 5;
    localparam int N_RANDOM   = 400;
    localparam int WATCHDOG   = 20000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;

    logic [AW-1:0] rs_dec = '0, rt_dec = '0, rs_exe = '0, rt_exe = '0;
    logic [AW-1:0] mem_dst = '0, wb_dst = '0;
    logic          ld = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0, br = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          st_f, st_d, fl_d, fl_e;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctrl #(.AW(AW)) u_hazard_ctrl (
        .rs_dec_i      (rs_dec),
        .rt_dec_i      (rt_dec),
        .rs_exe_i      (rs_exe),
        .rt_exe_i      (rt_exe),
        .exe_is_load_i (ld),
        .mem_dst_i     (mem_dst),
        .mem_wen_i     (mem_wen),
        .wb_dst_i      (wb_dst),
        .wb_wen_i      (wb_wen),
        .br_taken_i    (br),
        .fwd_a_o       (fwd_a),
        .fwd_b_o       (fwd_b),
        .stall_fetch_o (st_f),
        .stall_dec_o   (st_d),
        .flush_dec_o   (fl_d),
        .flush_exe_o   (fl_e)
    );

    // Expected bypass select from the requirements.
    function automatic logic [1:0] exp_fwd(input logic [AW-1:0] s);
        if (mem_wen && mem_dst != 0 && mem_dst == s) return 2'b10;
        if (wb_wen && wb_dst != 0 && wb_dst == s)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_luse();
        return ld && (rs_dec == rt_exe || rt_dec == rt_exe);
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string fwd_tag(input logic [1:0] e, input logic [AW-1:0] s);
        if (e == 2'b10) return "R1";
        if (e == 2'b01) return "R2";
        if ((mem_wen && mem_dst == s) || (wb_wen && wb_dst == s)) return "R4";
        return "R3";
    endfunction

    // Compare every output against the reference for the applied inputs.
    task automatic check_all();
        logic [1:0] ea, eb;
        logic       lu, hold;
        ea   = exp_fwd(rs_exe);
        eb   = exp_fwd(rt_exe);
        lu   = exp_luse();
        hold = lu && !br;
        chk(fwd_tag(ea, rs_exe), fwd_a, ea);
        chk({fwd_tag(eb, rt_exe), "/R5"}, fwd_b, eb);
        if (br) begin
            chk("R8 stall", {st_f, st_d}, 2'b00);
            chk("R8 flush", {fl_d, fl_e}, 2'b11);
        end else if (hold) begin
            chk("R6 stall", {st_f, st_d}, 2'b11);
            chk("R6 flush", {fl_d, fl_e}, 2'b01);
        end else if (!ld && (rs_dec == rt_exe || rt_dec == rt_exe)) begin
            chk("R7", {st_f, st_d, fl_d, fl_e}, 2'b00);
            chk("R7 flush", {fl_d, fl_e}, 2'b00);
        end else begin
            chk("R9 stall", {st_f, st_d}, 2'b00);
            chk("R9 flush", {fl_d, fl_e}, 2'b00);
        end
    endtask

    // Drive after a rising edge, check at the following falling edge.
    task automatic apply(input logic [AW-1:0] a, b, c, d, input logic l,
                         input logic [AW-1:0] md, input logic mw,
                         input logic [AW-1:0] wd, input logic ww, input logic bt);
        @(posedge clk);
        rs_dec = a; rt_dec = b; rs_exe = c; rt_exe = d; ld = l;
        mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww; br = bt;
        @(negedge clk);
        check_all();
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state: all zero inputs give register-file selects and no control (R3, R9).
        @(negedge clk);
        check_all();
        // R1 over R2: both stages write the operand's source.
        apply(5'd1, 5'd2, 5'd7, 5'd8, 1'b0, 5'd7, 1'b1, 5'd7, 1'b1, 1'b0);
        // R2 alone, and R5: B from memory while A from writeback.
        apply(5'd1, 5'd2, 5'd7, 5'd9, 1'b0, 5'd9, 1'b1, 5'd7, 1'b1, 1'b0);
        // R4: zero register with both writers active.
        apply(5'd3, 5'd4, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0);
        // R4: matching index but write flags low.
        apply(5'd3, 5'd4, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 5'd6, 1'b0, 1'b0);
        // R6: load-use via rs, then via rt.
        apply(5'd5, 5'd4, 5'd1, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        apply(5'd2, 5'd5, 5'd1, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        // R7: same match but not a load.
        apply(5'd5, 5'd5, 5'd1, 5'd5, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        // R8: taken branch with a load-use pattern present.
        apply(5'd5, 5'd5, 5'd1, 5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1);
        // Random patterns from a small index range to make coincidences frequent.
        for (int i = 0; i < N_RANDOM; i++) begin
            apply(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                  1'($urandom_range(0, 2) == 0),
                  AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 3) == 0));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule